// File: doc/BRIEF.md
# Debug Indirect Memory Access Port

This block gives an external debug agent a path into system memory through three registers: a control/status word, an address register and a data register. The agent sets up the transfer by choosing an access size, a direction, a target page and whether the address steps forward on its own. The port then places requests on a simple bus. The bus has a per-page ready vector, a request strobe and a one-cycle response carrying an error code, an access code and read data.

Writes are launched by loading the data register while the port is in write mode. Reads are launched by loading the address register while it is in read mode. With auto-increment on, each time the agent consumes the data register in read mode the port steps the address and issues the next read. In write mode the address steps after each write that completes cleanly, and the next write waits for new data. The port reports several things. It has a live ready bit for the selected page and a two-bit progress field. It captures the first non-zero error code, and it holds a sticky overrun flag that is set when a register is written during an outstanding access. A port-reset bit clears this status, and that bit is set out of reset.

Top module: `dbg_mem_port`

## Requirements
- R1: After reset no request is issued, and the control word reads 0x2000_0000 plus bit 19 equal to the ready of page 0.
- R2: While the port-reset bit (29) is 1, no request is launched. Data and address writes are still stored.
- R3: In write mode (bit 0 = 1), a data-register write while the port is idle launches one write with the current address, size and data. The status field (bits 17:16) is 01 while the access is in flight and 10 after a clean response.
- R4: In read mode (bit 0 = 0), an address-register write while idle launches one read. The response data is loaded into the data register, and the response code is shown in bits 27:24.
- R5: With auto-increment (bit 1) set in read mode, a data-register read while idle advances the address by 1 << size and launches the next read. Without auto-increment, such a read launches nothing.
- R6: With auto-increment set in write mode, the address advances by 1 << size only after a write completes without error. No further write starts until the data register is written again.
- R7: The size field (bits 10:8) is the log2 of the byte count. Values above 3 act as 3 on the bus size output and for the step.
- R8: A non-zero bus error gives status 11. The first non-zero code is held in bits 23:20, and later errors do not replace it.
- R9: While a captured error code is non-zero, auto-increment does nothing, although bit 1 still reads 1. Stepping resumes after a port reset.
- R10: A control, address or data write during an outstanding access sets bit 18 and is dropped. Bit 18 stays set until a port reset.
- R11: Writing 1 to bit 29 aborts any request in flight and clears the error code, overrun flag, access code and status field. The address and other fields are kept.
- R12: Bit 19 reads the live ready input of the page selected by bits 6:4.
- R13: A request stays asserted with a stable address until the selected page's ready is high.
- R14: Bits 15:12, 3:2, size and page read back as written. Bits 31:30, 28, 11 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (acts on data register) |
| reg_sel_i | input | 2 | Register select: 0 control, 1 address, 2 data |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Selected register contents |
| bus_req_o | output | 1 | Request valid |
| bus_we_o | output | 1 | Request is a write |
| bus_addr_o | output | ADDR_W | Request address |
| bus_size_o | output | 2 | Log2 byte count of the request |
| bus_page_o | output | 3 | Target page |
| bus_wdata_o | output | DATA_W | Write data |
| bus_ready_i | input | NUM_PAGES | Per-page ready |
| bus_rsp_valid_i | input | 1 | Response strobe |
| bus_rsp_err_i | input | 4 | Response error code, 0 when clean |
| bus_rsp_code_i | input | 4 | Response access code |
| bus_rsp_rdata_i | input | DATA_W | Read response data |

## Verification
The assertions assume that the bus gives exactly one response for each accepted request. They also assume that the response arrives no earlier than the cycle after acceptance, and that no response appears when nothing is outstanding. The bench responder keeps to this: it counts a request only when it sees the strobe together with the selected page's ready, then pulses the response strobe a fixed two cycles later. Aborts are tested only on requests that were never accepted, so no stray response is produced.

// File: rtl/dbg_mem_pkg.sv
package dbg_mem_pkg;
  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_ADDR = 2'd1;
  localparam logic [1:0] SEL_DATA = 2'd2;
  localparam int PRST_BIT = 29;

  typedef enum logic [1:0] {
    PST_IDLE = 2'b00,
    PST_PEND = 2'b01,
    PST_OK   = 2'b10,
    PST_ERR  = 2'b11
  } pstat_e;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} seq_state_e;

  typedef struct packed {
    logic [3:0] qual;
    logic [2:0] size;
    logic [2:0] page;
    logic [1:0] ign;
    logic       inc;
    logic       wr;
  } ctrl_fields_t;

  function automatic logic [1:0] size_clamp(input logic [2:0] s);
    return s[2] ? 2'd3 : s[1:0];
  endfunction
endpackage

// File: rtl/dbg_mem_ctrl_regs.sv
module dbg_mem_ctrl_regs
  import dbg_mem_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ctrl_we_i,
  input  logic         busy_i,
  input  logic         prst_wr_i,
  input  ctrl_fields_t fields_wr_i,
  output ctrl_fields_t fields_o,
  output logic         prst_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fields_o <= '0;
      prst_o   <= 1'b1;
    end else if (ctrl_we_i) begin
      if (!busy_i) begin
        fields_o <= fields_wr_i;
        prst_o   <= prst_wr_i;
      end else if (prst_wr_i) begin
        // busy: only the abort request survives
        prst_o <= 1'b1;
      end
    end
  end

  // R10
  ctrl_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(fields_o));
endmodule

// File: rtl/dbg_mem_addr_gen.sv
module dbg_mem_addr_gen
  import dbg_mem_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  logic              inc_i,
  input  logic [2:0]        size_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] step;
  assign step = ADDR_W'(1) << size_clamp(size_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_o <= '0;
    else if (load_i) addr_o <= load_val_i;
    else if (inc_i)  addr_o <= addr_o + step;
  end

  // R6
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && !inc_i |=> $stable(addr_o));
endmodule

// File: rtl/dbg_mem_seq.sv
module dbg_mem_seq
  import dbg_mem_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 64,
  parameter int NUM_PAGES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              port_rst_i,
  input  logic              wr_mode_i,
  input  logic              inc_en_i,
  input  logic [2:0]        size_i,
  input  logic [2:0]        page_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ctrl_we_i,
  input  logic              addr_we_i,
  input  logic              data_we_i,
  input  logic              data_re_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              busy_o,
  output logic              addr_inc_o,
  output logic              sel_ready_o,
  output logic [DATA_W-1:0] data_o,
  output logic [3:0]        err_code_o,
  output logic [3:0]        acc_code_o,
  output logic              overrun_o,
  output pstat_e            pstat_o,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [1:0]        bus_size_o,
  output logic [2:0]        bus_page_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [NUM_PAGES-1:0] bus_ready_i,
  input  logic              bus_rsp_valid_i,
  input  logic [3:0]        bus_rsp_err_i,
  input  logic [3:0]        bus_rsp_code_i,
  input  logic [DATA_W-1:0] bus_rsp_rdata_i
);
  seq_state_e state_q, state_d;
  logic launch, chain_rd, rsp_take, rsp_err, frozen, any_we;

  always_comb begin
    sel_ready_o = 1'b0;
    for (int p = 0; p < NUM_PAGES; p++)
      if (page_i == 3'(p)) sel_ready_o = bus_ready_i[p];
  end

  assign busy_o   = (state_q != ST_IDLE);
  assign frozen   = (err_code_o != 4'd0);
  assign any_we   = ctrl_we_i | addr_we_i | data_we_i;
  assign chain_rd = data_re_i & !wr_mode_i & inc_en_i & !frozen;
  assign launch   = !busy_o & !port_rst_i &
                    ((data_we_i & wr_mode_i) | (addr_we_i & !wr_mode_i) | chain_rd);
  assign rsp_take = (state_q == ST_WAIT) & bus_rsp_valid_i & !port_rst_i;
  assign rsp_err  = (bus_rsp_err_i != 4'd0);

  assign addr_inc_o = (!busy_o & !port_rst_i & chain_rd) |
                      (rsp_take & wr_mode_i & inc_en_i & !rsp_err & !frozen);

  always_comb begin
    state_d = state_q;
    if (port_rst_i) state_d = ST_IDLE;
    else begin
      unique case (state_q)
        ST_IDLE: if (launch) state_d = ST_REQ;
        ST_REQ:  if (sel_ready_o) state_d = ST_WAIT;
        ST_WAIT: if (bus_rsp_valid_i) state_d = ST_IDLE;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      data_o     <= '0;
      err_code_o <= '0;
      acc_code_o <= '0;
      overrun_o  <= 1'b0;
      pstat_o    <= PST_IDLE;
    end else begin
      state_q <= state_d;
      if (data_we_i && !busy_o)            data_o <= wdata_i;
      else if (rsp_take && !wr_mode_i)     data_o <= bus_rsp_rdata_i;
      if (port_rst_i) begin
        err_code_o <= '0;
        acc_code_o <= '0;
        overrun_o  <= 1'b0;
        pstat_o    <= PST_IDLE;
      end else begin
        if (any_we && busy_o) overrun_o <= 1'b1;
        if (launch) pstat_o <= PST_PEND;
        if (rsp_take) begin
          pstat_o <= rsp_err ? PST_ERR : PST_OK;
          if (rsp_err && !frozen) err_code_o <= bus_rsp_err_i;
          if (!wr_mode_i)         acc_code_o <= bus_rsp_code_i;
        end
      end
    end
  end

  assign bus_req_o   = (state_q == ST_REQ);
  assign bus_we_o    = wr_mode_i;
  assign bus_addr_o  = addr_i;
  assign bus_size_o  = size_clamp(size_i);
  assign bus_page_o  = page_i;
  assign bus_wdata_o = data_o;

  // R13
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !sel_ready_o && !port_rst_i |=> bus_req_o && $stable(bus_addr_o));
  // R10
  overrun_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o && !port_rst_i |=> overrun_o);
  // R8
  err_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_code_o != 4'd0) && !port_rst_i |=> $stable(err_code_o));
  // R2
  no_req_in_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_rst_i |=> !bus_req_o);
  // R3
  pend_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> pstat_o == PST_PEND);
endmodule

// File: rtl/dbg_mem_port.sv
module dbg_mem_port
  import dbg_mem_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 64,
  parameter int NUM_PAGES = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 reg_we_i,
  input  logic                 reg_re_i,
  input  logic [1:0]           reg_sel_i,
  input  logic [DATA_W-1:0]    reg_wdata_i,
  output logic [DATA_W-1:0]    reg_rdata_o,
  output logic                 bus_req_o,
  output logic                 bus_we_o,
  output logic [ADDR_W-1:0]    bus_addr_o,
  output logic [1:0]           bus_size_o,
  output logic [2:0]           bus_page_o,
  output logic [DATA_W-1:0]    bus_wdata_o,
  input  logic [NUM_PAGES-1:0] bus_ready_i,
  input  logic                 bus_rsp_valid_i,
  input  logic [3:0]           bus_rsp_err_i,
  input  logic [3:0]           bus_rsp_code_i,
  input  logic [DATA_W-1:0]    bus_rsp_rdata_i
);
  localparam int CTRL_W = 32;

  ctrl_fields_t fields, fields_wr;
  logic ctrl_we, addr_we, data_we, data_re, prst_q, port_rst, busy, addr_inc, sel_ready;
  logic overrun;
  logic [3:0] err_code, acc_code;
  pstat_e pstat;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] data;
  logic [CTRL_W-1:0] ctrl_word;

  assign ctrl_we  = reg_we_i && (reg_sel_i == SEL_CTRL);
  assign addr_we  = reg_we_i && (reg_sel_i == SEL_ADDR);
  assign data_we  = reg_we_i && (reg_sel_i == SEL_DATA);
  assign data_re  = reg_re_i && (reg_sel_i == SEL_DATA);
  assign port_rst = prst_q | (ctrl_we & reg_wdata_i[PRST_BIT]);

  assign fields_wr = '{qual: reg_wdata_i[15:12], size: reg_wdata_i[10:8],
                       page: reg_wdata_i[6:4],   ign:  reg_wdata_i[3:2],
                       inc:  reg_wdata_i[1],     wr:   reg_wdata_i[0]};

  dbg_mem_ctrl_regs i_ctrl (
    .clk_i, .rst_ni,
    .ctrl_we_i   (ctrl_we),
    .busy_i      (busy),
    .prst_wr_i   (reg_wdata_i[PRST_BIT]),
    .fields_wr_i (fields_wr),
    .fields_o    (fields),
    .prst_o      (prst_q)
  );

  dbg_mem_addr_gen #(.ADDR_W(ADDR_W)) i_addr (
    .clk_i, .rst_ni,
    .load_i     (addr_we && !busy),
    .load_val_i (reg_wdata_i[ADDR_W-1:0]),
    .inc_i      (addr_inc),
    .size_i     (fields.size),
    .addr_o     (addr)
  );

  dbg_mem_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_PAGES(NUM_PAGES)) i_seq (
    .clk_i, .rst_ni,
    .port_rst_i (port_rst),
    .wr_mode_i  (fields.wr),
    .inc_en_i   (fields.inc),
    .size_i     (fields.size),
    .page_i     (fields.page),
    .addr_i     (addr),
    .ctrl_we_i  (ctrl_we),
    .addr_we_i  (addr_we),
    .data_we_i  (data_we),
    .data_re_i  (data_re),
    .wdata_i    (reg_wdata_i),
    .busy_o     (busy),
    .addr_inc_o (addr_inc),
    .sel_ready_o(sel_ready),
    .data_o     (data),
    .err_code_o (err_code),
    .acc_code_o (acc_code),
    .overrun_o  (overrun),
    .pstat_o    (pstat),
    .bus_req_o, .bus_we_o, .bus_addr_o, .bus_size_o, .bus_page_o, .bus_wdata_o,
    .bus_ready_i, .bus_rsp_valid_i, .bus_rsp_err_i, .bus_rsp_code_i, .bus_rsp_rdata_i
  );

  assign ctrl_word = {2'b00, prst_q, 1'b0, acc_code, err_code, sel_ready, overrun,
                      pstat, fields.qual, 1'b0, fields.size, 1'b0, fields.page,
                      fields.ign, fields.inc, fields.wr};

  always_comb begin
    unique case (reg_sel_i)
      SEL_CTRL: reg_rdata_o = DATA_W'(ctrl_word);
      SEL_ADDR: reg_rdata_o = DATA_W'(addr);
      SEL_DATA: reg_rdata_o = data;
      default:  reg_rdata_o = '0;
    endcase
  end
endmodule

// File: tb/test_dbg_mem_port.sv
`timescale 1ns/1ps
module test_dbg_mem_port;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 64;
  localparam int NP     = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 0, reg_re = 0;
  logic [1:0] reg_sel = 0;
  logic [DATA_W-1:0] reg_wdata = '0, reg_rdata;
  logic bus_req, bus_we;
  logic [ADDR_W-1:0] bus_addr;
  logic [1:0] bus_size;
  logic [2:0] bus_page;
  logic [DATA_W-1:0] bus_wdata;
  logic [NP-1:0] ready = '1;
  logic rsp_valid = 0;
  logic [3:0] rsp_err = 0, err_inject = 0;
  logic [3:0] rsp_code = 4'h5;
  logic [DATA_W-1:0] rsp_rdata = '0;

  int checks = 0, failures = 0, req_cnt = 0, pend = 0;
  logic [ADDR_W-1:0] last_addr = '0;
  logic [1:0] last_size = '0;
  logic [DATA_W-1:0] last_wdata = '0;
  logic last_we = 0;

  always #2.5 clk = ~clk;

  dbg_mem_port i_dbg_mem_port (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_re_i(reg_re),
    .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .bus_req_o(bus_req), .bus_we_o(bus_we), .bus_addr_o(bus_addr),
    .bus_size_o(bus_size), .bus_page_o(bus_page), .bus_wdata_o(bus_wdata),
    .bus_ready_i(ready), .bus_rsp_valid_i(rsp_valid), .bus_rsp_err_i(rsp_err),
    .bus_rsp_code_i(rsp_code), .bus_rsp_rdata_i(rsp_rdata)
  );

  function automatic logic [DATA_W-1:0] pat(input logic [ADDR_W-1:0] a);
    return {a, ~a};
  endfunction

  // bus responder: fixed two-cycle latency
  always @(negedge clk) begin
    #1;
    rsp_valid = 1'b0;
    if (pend > 0) begin
      pend = pend - 1;
      if (pend == 0) begin
        rsp_valid = 1'b1;
        rsp_err   = err_inject;
        rsp_rdata = pat(last_addr);
      end
    end
    if (bus_req && ready[bus_page]) begin
      req_cnt++;
      last_addr = bus_addr; last_size = bus_size;
      last_wdata = bus_wdata; last_we = bus_we;
      pend = 2;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [63:0] d);
    @(negedge clk); reg_we = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [1:0] sel, input bit strobe, output logic [63:0] d);
    @(negedge clk); reg_re = strobe; reg_sel = sel;
    #2 d = reg_rdata;
    @(negedge clk); reg_re = 0;
  endtask

  task automatic wait_done();
    int n = 0;
    reg_sel = 2'd0;
    do begin
      @(negedge clk); #2; n++;
    end while ((reg_rdata[17:16] == 2'b01) && n < 100);
    if (n >= 100) chk("wait_done timeout", 1, 0);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  typedef struct packed {
    logic [2:0]  size;
    logic [31:0] addr;
    logic [63:0] data;
    logic [1:0]  exp_size;
  } vec_t;
  localparam vec_t VEC [4] = '{
    '{3'd0, 32'h0000_0010, 64'h0000_0000_0000_0011, 2'd0},
    '{3'd1, 32'h0000_0020, 64'h0000_0000_0000_2222, 2'd1},
    '{3'd3, 32'h0000_0040, 64'h0123_4567_89AB_CDEF, 2'd3},
    '{3'd6, 32'h0000_0080, 64'hDEAD_BEEF_0000_0006, 2'd3}
  };

  initial begin
    #(200000 * 5);
    chk("watchdog expired", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [63:0] v;
    int c0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(1);
    // R1 reset state
    rd(2'd0, 0, v);
    chk("R1 ctrl reset", v, 64'h2008_0000);
    chk("R1 no req", bus_req, 0);

    // R2 held in port reset
    wr(2'd0, 64'h2000_0001);
    wr(2'd1, 64'h0000_0100);
    wr(2'd2, 64'h5A5A);
    idle(6);
    chk("R2 no request", req_cnt, 0);
    rd(2'd2, 0, v);
    chk("R2 data stored", v, 64'h5A5A);

    // R3 R7 vector table
    foreach (VEC[i]) begin
      c0 = req_cnt;
      wr(2'd0, {53'd0, VEC[i].size, 8'h01});
      wr(2'd1, 64'(VEC[i].addr));
      wr(2'd2, VEC[i].data);
      wait_done();
      chk("R3 one req", req_cnt, c0 + 1);
      chk("R3 addr", last_addr, VEC[i].addr);
      chk("R3 wdata", last_wdata, VEC[i].data);
      chk("R3 we", last_we, 1);
      chk("R7 bus size", last_size, VEC[i].exp_size);
      chk("R3 status ok", reg_rdata[17:16], 2'b10);
    end

    // R4 plain read
    wr(2'd0, 64'h0000_0200);
    wr(2'd1, 64'h0000_0100);
    wait_done();
    chk("R4 acc code", reg_rdata[27:24], 4'h5);
    chk("R4 we", last_we, 0);
    rd(2'd2, 1, v);
    chk("R4 read data", v, pat(32'h100));
    c0 = req_cnt;
    idle(6);
    chk("R5 no chain without inc", req_cnt, c0);

    // R5 auto-increment read, size 3
    wr(2'd0, 64'h0000_0302);
    wr(2'd1, 64'h0000_1000);
    wait_done();
    rd(2'd2, 1, v);
    chk("R5 first data", v, pat(32'h1000));
    wait_done();
    chk("R5 chained addr", last_addr, 32'h1008);
    rd(2'd1, 0, v);
    chk("R5 addr reg", v, 64'h1008);
    rd(2'd2, 0, v);
    chk("R5 chained data", v, pat(32'h1008));

    // R6 auto-increment write, size 1
    wr(2'd0, 64'h0000_0103);
    wr(2'd1, 64'h0000_2000);
    c0 = req_cnt;
    wr(2'd2, 64'h77);
    wait_done();
    rd(2'd1, 0, v);
    chk("R6 addr after write", v, 64'h2002);
    idle(6);
    chk("R6 no extra write", req_cnt, c0 + 1);
    wr(2'd2, 64'h78);
    wait_done();
    chk("R6 next write addr", last_addr, 32'h2002);

    // R10 R12 R13 overrun with stalled page
    wr(2'd0, 64'h0000_0001);
    wr(2'd1, 64'h0000_4000);
    ready = '0;
    wr(2'd2, 64'hAA);
    idle(3);
    chk("R13 req held", bus_req, 1);
    chk("R13 addr held", bus_addr, 32'h4000);
    rd(2'd0, 0, v);
    chk("R12 ready low", v[19], 0);
    wr(2'd1, 64'h0000_5555);
    rd(2'd0, 0, v);
    chk("R10 overrun set", v[18], 1);
    rd(2'd1, 0, v);
    chk("R10 addr write dropped", v, 64'h4000);
    ready = '1;
    wait_done();
    chk("R10 overrun sticky", reg_rdata[18], 1);
    chk("R10 access addr", last_addr, 32'h4000);

    // R11 port reset clears status, keeps fields
    wr(2'd0, 64'h2000_0001);
    wr(2'd0, 64'h0000_0001);
    rd(2'd0, 0, v);
    chk("R11 status cleared", v, 64'h0008_0001);
    rd(2'd1, 0, v);
    chk("R11 addr kept", v, 64'h4000);

    // R8 R9 errors
    wr(2'd0, 64'h0000_0003);
    wr(2'd1, 64'h0000_3000);
    err_inject = 4'h6;
    wr(2'd2, 64'h1);
    wait_done();
    chk("R8 err status", reg_rdata[17:16], 2'b11);
    chk("R8 err code", reg_rdata[23:20], 4'h6);
    chk("R9 inc bit kept", reg_rdata[1], 1);
    err_inject = 4'h9;
    wr(2'd2, 64'h2);
    wait_done();
    chk("R8 first err kept", reg_rdata[23:20], 4'h6);
    err_inject = 4'h0;
    wr(2'd2, 64'h3);
    wait_done();
    chk("R8 ok status", reg_rdata[17:16], 2'b10);
    rd(2'd1, 0, v);
    chk("R9 addr frozen", v, 64'h3000);
    wr(2'd0, 64'h2000_0003);
    wr(2'd0, 64'h0000_0003);
    wr(2'd2, 64'h4);
    wait_done();
    chk("R11 err cleared", reg_rdata[23:20], 4'h0);
    rd(2'd1, 0, v);
    chk("R9 inc resumed", v, 64'h3001);

    // R11 abort of pending request
    wr(2'd0, 64'h0000_0001);
    ready = '0;
    c0 = req_cnt;
    wr(2'd2, 64'h5);
    wr(2'd0, 64'h2000_0001);
    idle(1);
    chk("R11 req aborted", bus_req, 0);
    rd(2'd0, 0, v);
    chk("R11 abort status", v[27:0], 28'h000_0001);
    ready = '1;
    wr(2'd0, 64'h0000_0001);
    idle(6);
    chk("R11 no stray req", req_cnt, c0);

    // R12 page select
    ready = 8'b1111_1011;
    wr(2'd0, 64'h0000_0021);
    rd(2'd0, 0, v);
    chk("R12 page2 not ready", v[19], 0);
    wr(2'd0, 64'h0000_0011);
    rd(2'd0, 0, v);
    chk("R12 page1 ready", v[19], 1);
    ready = '1;

    // R14 stored bits and reserved zeros
    wr(2'd0, 64'hDFFF_FFFF);
    rd(2'd0, 0, v);
    chk("R14 readback", v, 64'h0008_F77F);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule